// File: doc/BRIEF.md
# Dual-Supply Rail Switch Sequencer

This block sits in an always-on domain and moves a processor core between two discrete supply rails, a high one and a low one. Each rail reaches the core through a bank of parallel power gates, and the sequencer drives one enable vector per bank. A rail change is break-before-make. The core is stalled first, and the sequencer waits for the core to confirm the stall. It then opens every gate on both rails and holds them all open for a programmed dead time. After that it closes the target rail's gates one at a time, on a fixed cadence. The stall is lifted only after the whole target bank is conducting.

A workload monitor outside the block raises `req_valid` with the wanted rail on `req_rail`. It also supplies the dead time in cycles on `dead_cycles`, which is captured when the request is accepted. The block has five named states:
- `ST_IDLE` waits for a request.
- `ST_HOLD` asserts the stall and waits for the acknowledge.
- `ST_CUT` opens all gates.
- `ST_DEAD` counts the dead time.
- `ST_RAMP` adds target gates one by one.

Its transitions are:
- `ST_IDLE`→`ST_HOLD` on a request for the other rail.
- `ST_HOLD`→`ST_CUT` on stall acknowledge.
- `ST_CUT`→`ST_DEAD` unconditionally.
- `ST_DEAD`→`ST_RAMP` when the dead count expires.
- `ST_RAMP`→`ST_IDLE` when the target bank is full.

Top module: `rail_switch_seq`

## Requirements
- R1: After reset, `gate_hi` is all ones, `gate_lo` is all zeros, `rail_sel` is 0, and `stall` and `busy` are low. The rail encoding is 0 = high rail, 1 = low rail.
- R2: In idle, a `req_valid` whose `req_rail` differs from `rail_sel` raises `stall` and `busy` in the next cycle. A request naming the rail already selected leaves `stall`, `busy` and both gate vectors unchanged.
- R3: While `stall_ack` is low, both gate vectors keep their values. No gate bit changes in a cycle where `stall` is low.
- R4: After the acknowledge, both gate vectors are all zero for exactly D consecutive cycles. D is the value `dead_cycles` held in the cycle the request was accepted, and a value of 0 counts as 1. Both vectors are never nonzero at the same time.
- R5: The target bank turns on with bit 0 first. One further bit, in rising index order, is added every STEP_CYC cycles until all GATE_N bits are set, so j cycles into the ramp the vector holds min(j/STEP_CYC+1, GATE_N) low-order ones.
- R6: `rail_sel` takes the target value in the same cycle that bit 0 of the target bank turns on. The vector of the previous rail stays all zero from then on.
- R7: `stall` and `busy` fall exactly one cycle after the cycle in which the last target gate bit is first seen set.
- R8: A request that arrives while `busy` is high is dropped. It does not alter the switch in progress, and it does not start a new one after the return to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Rail change request strobe |
| req_rail | input | 1 | Wanted rail (0 high, 1 low) |
| dead_cycles | input | DEAD_W | Dead time in cycles, captured at acceptance |
| stall_ack | input | 1 | Core confirms it is stalled |
| stall | output | 1 | Stall request to the core |
| gate_hi | output | GATE_N | Enables for the high-rail gates |
| gate_lo | output | GATE_N | Enables for the low-rail gates |
| rail_sel | output | 1 | Rail currently powering the core |
| busy | output | 1 | A switch is in progress |

## Verification
The bench checks dead-time values of 0, 1 and several cycles. A wrong clamp or an off-by-one counter would show up as a dead window of the wrong length, or as a rail overlap. It holds the acknowledge back for several cycles and watches that no gate moves early; a sequencer that skipped the handshake would cut power while the core still runs. It changes `dead_cycles` after acceptance and injects competing requests during a switch, which catches a design that samples the delay late or chains a second switch. The ramp is checked bit by bit against the cadence, and the stall release is checked to the exact cycle, which exposes an early release or a wrong step order.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HOLD = 3'd1,
        ST_CUT  = 3'd2,
        ST_DEAD = 3'd3,
        ST_RAMP = 3'd4
    } seq_state_t;

    localparam logic RAIL_HIGH = 1'b0;
    localparam logic RAIL_LOW  = 1'b1;
    localparam int   RAIL_NUM  = 2;

endpackage

// File: rtl/rail_seq_dead_timer.sv
module rail_seq_dead_timer #(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              dec,
    input  logic [DEAD_W-1:0] load_val,
    output logic              done
);

    logic [DEAD_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == DEAD_W'(1));

    // R4: a counting timer never reaches zero without passing the done point
    assert_timer_no_underrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt_q == DEAD_W'(1)) |=> (cnt_q == '0));

endmodule

// File: rtl/rail_seq_gate_ramp.sv
module rail_seq_gate_ramp #(
    parameter int   GATE_N   = 8,
    parameter int   STEP_CYC = 4,
    parameter logic ON_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              start,
    input  logic              advance,
    output logic [GATE_N-1:0] gates,
    output logic              full
);

    localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CW-1:0] STEP_LAST = CW'(STEP_CYC - 1);

    logic [GATE_N-1:0] gates_q;
    logic [CW-1:0]     step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gates_q <= {GATE_N{ON_RESET}};
            step_q  <= '0;
        end else if (clear) begin
            gates_q <= '0;
            step_q  <= '0;
        end else if (start) begin
            gates_q <= GATE_N'(1);
            step_q  <= '0;
        end else if (advance && !full) begin
            if (step_q == STEP_LAST) begin
                gates_q <= (gates_q << 1) | GATE_N'(1);
                step_q  <= '0;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    assign gates = gates_q;
    assign full  = &gates_q;

    // R5: at most one gate is added per cycle
    assert_one_gate_per_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ($countones(gates_q) <= $countones($past(gates_q)) + 1));

    // R5: the enabled gates always form a contiguous run from bit 0
    assert_low_bits_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((gates_q & (gates_q + GATE_N'(1))) == '0));

endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
    import rail_seq_pkg::*;
#(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_rail,
    input  logic [DEAD_W-1:0] dead_cycles,
    input  logic              stall_ack,
    input  logic              dead_done,
    input  logic              tgt_full,
    output logic              tgt_rail,
    output logic [DEAD_W-1:0] dead_val,
    output logic              rail_sel,
    output logic              stall,
    output logic              busy,
    output logic              cut_all,
    output logic              timer_load,
    output logic              timer_dec,
    output logic              ramp_start,
    output logic              ramp_adv
);

    seq_state_t        state_q, state_d;
    logic              tgt_q;
    logic              rail_q;
    logic [DEAD_W-1:0] dead_q;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && req_valid && (req_rail != rail_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)     state_d = ST_HOLD;
            ST_HOLD: if (stall_ack)  state_d = ST_CUT;
            ST_CUT:                  state_d = ST_DEAD;
            ST_DEAD: if (dead_done)  state_d = ST_RAMP;
            ST_RAMP: if (tgt_full)   state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= RAIL_HIGH;
            rail_q  <= RAIL_HIGH;
            dead_q  <= DEAD_W'(1);
        end else begin
            state_q <= state_d;
            if (accept) begin
                tgt_q  <= req_rail;
                dead_q <= (dead_cycles == '0) ? DEAD_W'(1) : dead_cycles;
            end
            if (state_q == ST_DEAD && dead_done) begin
                rail_q <= tgt_q;
            end
        end
    end

    always_comb begin
        stall      = (state_q != ST_IDLE);
        busy       = (state_q != ST_IDLE);
        cut_all    = (state_q == ST_CUT);
        timer_load = (state_q == ST_CUT);
        timer_dec  = (state_q == ST_DEAD);
        ramp_start = (state_q == ST_DEAD) && dead_done;
        ramp_adv   = (state_q == ST_RAMP);
    end

    assign tgt_rail = tgt_q;
    assign dead_val = dead_q;
    assign rail_sel = rail_q;

    // R3: no progress past the hold state until the core acknowledges
    assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !stall_ack) |=> (state_q == ST_HOLD));

    // R2: a request for the present rail leaves the sequencer idle
    assert_same_rail_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && req_rail == rail_q) |=> (state_q == ST_IDLE));

    // R8: the target and dead time stay fixed during a switch
    assert_busy_request_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(tgt_q) && $stable(dead_q)));

endmodule

// File: rtl/rail_switch_seq.sv
module rail_switch_seq
    import rail_seq_pkg::*;
#(
    parameter int GATE_N   = 8,
    parameter int STEP_CYC = 4,
    parameter int DEAD_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_rail,
    input  logic [DEAD_W-1:0] dead_cycles,
    input  logic              stall_ack,
    output logic              stall,
    output logic [GATE_N-1:0] gate_hi,
    output logic [GATE_N-1:0] gate_lo,
    output logic              rail_sel,
    output logic              busy
);

    logic              tgt_rail;
    logic [DEAD_W-1:0] dead_val;
    logic              dead_done;
    logic              cut_all;
    logic              timer_load;
    logic              timer_dec;
    logic              ramp_start;
    logic              ramp_adv;
    logic              tgt_full;

    logic [GATE_N-1:0] bank_gates [RAIL_NUM];
    logic              bank_full  [RAIL_NUM];

    rail_seq_fsm #(
        .DEAD_W (DEAD_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_rail    (req_rail),
        .dead_cycles (dead_cycles),
        .stall_ack   (stall_ack),
        .dead_done   (dead_done),
        .tgt_full    (tgt_full),
        .tgt_rail    (tgt_rail),
        .dead_val    (dead_val),
        .rail_sel    (rail_sel),
        .stall       (stall),
        .busy        (busy),
        .cut_all     (cut_all),
        .timer_load  (timer_load),
        .timer_dec   (timer_dec),
        .ramp_start  (ramp_start),
        .ramp_adv    (ramp_adv)
    );

    rail_seq_dead_timer #(
        .DEAD_W (DEAD_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .dec      (timer_dec),
        .load_val (dead_val),
        .done     (dead_done)
    );

    for (genvar r = 0; r < RAIL_NUM; r++) begin : g_bank
        localparam logic ON_AT_RESET = (r == int'(RAIL_HIGH));
        logic sel_this;
        assign sel_this = (tgt_rail == 1'(r));

        rail_seq_gate_ramp #(
            .GATE_N   (GATE_N),
            .STEP_CYC (STEP_CYC),
            .ON_RESET (ON_AT_RESET)
        ) ramp_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (cut_all),
            .start   (ramp_start && sel_this),
            .advance (ramp_adv && sel_this),
            .gates   (bank_gates[r]),
            .full    (bank_full[r])
        );
    end

    assign gate_hi  = bank_gates[int'(RAIL_HIGH)];
    assign gate_lo  = bank_gates[int'(RAIL_LOW)];
    assign tgt_full = tgt_rail ? bank_full[int'(RAIL_LOW)] : bank_full[int'(RAIL_HIGH)];

    // R4: the two rails are never connected at once
    assert_no_rail_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !((|gate_hi) && (|gate_lo)));

    // R3: a gate may move only while the core is held
    assert_stall_covers_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(gate_hi) || !$stable(gate_lo)) |-> (stall && $past(stall)));

    // R7: stall is lifted only after the target bank was already full
    assert_release_after_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> $past(tgt_full));

    // R6: the selected rail moves only together with the first target gate
    assert_rail_sel_with_ramp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rail_sel) |-> ($countones(rail_sel ? gate_lo : gate_hi) == 1));

endmodule

// File: tb/rail_switch_seq_tb_top.sv
module rail_switch_seq_tb_top;

    localparam int NG = 8;
    localparam int KS = 3;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_rail = 1'b0;
    logic [DW-1:0] dead_cycles = '0;
    logic          stall_ack = 1'b0;
    logic          stall;
    logic [NG-1:0] gate_hi;
    logic [NG-1:0] gate_lo;
    logic          rail_sel;
    logic          busy;

    int checks = 0;
    int errors = 0;
    logic cur_rail = 1'b0;

    always #2 clk = ~clk;

    rail_switch_seq #(
        .GATE_N   (NG),
        .STEP_CYC (KS),
        .DEAD_W   (DW)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_rail    (req_rail),
        .dead_cycles (dead_cycles),
        .stall_ack   (stall_ack),
        .stall       (stall),
        .gate_hi     (gate_hi),
        .gate_lo     (gate_lo),
        .rail_sel    (rail_sel),
        .busy        (busy)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NG-1:0] bank(input logic r);
        return r ? gate_lo : gate_hi;
    endfunction

    function automatic logic [NG-1:0] low_ones(input int n);
        logic [NG-1:0] v = '0;
        for (int i = 0; i < NG; i++) if (i < n) v[i] = 1'b1;
        return v;
    endfunction

    task automatic test_reset();
        chk(gate_hi == '1, "R1 gate_hi", gate_hi, low_ones(NG));
        chk(gate_lo == '0, "R1 gate_lo", gate_lo, 0);
        chk(rail_sel == 1'b0, "R1 rail_sel", rail_sel, 0);
        chk(!stall && !busy, "R1 stall/busy", {stall, busy}, 0);
    endtask

    task automatic test_same_rail();
        logic [NG-1:0] hi0 = gate_hi;
        logic [NG-1:0] lo0 = gate_lo;
        req_valid = 1'b1;
        req_rail  = cur_rail;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!stall && !busy, "R2 same rail ignored", {stall, busy}, 0);
        @(negedge clk);
        chk(!stall && !busy, "R2 same rail still idle", {stall, busy}, 0);
        chk(gate_hi == hi0 && gate_lo == lo0, "R2 gates untouched", {gate_hi, gate_lo}, {hi0, lo0});
    endtask

    task automatic do_switch(input logic tgt, input int d, input int ack_dly, input bit inject);
        logic old = cur_rail;
        int deff = (d == 0) ? 1 : d;
        int phase = 0;
        int zc = 0;
        int j = 0;
        int jlast = -1;
        int pre = 0;
        bit done = 0;
        req_valid   = 1'b1;
        req_rail    = tgt;
        dead_cycles = DW'(d);
        @(negedge clk);
        req_valid   = 1'b0;
        dead_cycles = DW'(d + 7);
        chk(stall && busy, "R2 accept raises stall/busy", {stall, busy}, 3);
        for (int a = 0; a < ack_dly; a++) begin
            if (inject && a == 0) begin
                req_valid = 1'b1;
                req_rail  = old;
            end
            @(negedge clk);
            req_valid = 1'b0;
            chk(bank(old) == '1 && bank(tgt) == '0, "R3 gates held before ack",
                {bank(old), bank(tgt)}, {low_ones(NG), {NG{1'b0}}});
            chk(stall == 1'b1, "R3 stall held while waiting", stall, 1);
        end
        stall_ack = 1'b1;
        for (int c = 0; c < 2000 && !done; c++) begin
            @(negedge clk);
            if (!stall) begin
                stall_ack = 1'b0;
                done = 1;
                chk(!busy, "R7 busy falls with stall", busy, 0);
            end else begin
                chk(!((|gate_hi) && (|gate_lo)), "R4 no overlap", {gate_hi, gate_lo}, 0);
                if (phase == 0) begin
                    if (gate_hi == '0 && gate_lo == '0) begin
                        phase = 1;
                        zc = 1;
                    end else begin
                        pre++;
                        chk(bank(old) == '1, "R3 gates on until cut", bank(old), low_ones(NG));
                    end
                end else if (phase == 1 && gate_hi == '0 && gate_lo == '0) begin
                    zc++;
                end else begin
                    if (phase == 1) begin
                        phase = 2;
                        j = 0;
                        chk(zc == deff, "R4 dead window length", zc, deff);
                        chk(rail_sel == tgt, "R6 rail_sel at first gate", rail_sel, tgt);
                    end
                    begin
                        int ep = (j / KS + 1 > NG) ? NG : j / KS + 1;
                        chk(bank(tgt) == low_ones(ep), "R5 ramp pattern", bank(tgt), low_ones(ep));
                    end
                    chk(bank(old) == '0, "R6 old rail stays off", bank(old), 0);
                    chk(busy, "R7 busy during ramp", busy, 1);
                    jlast = j;
                    j++;
                end
            end
        end
        chk(done, "R7 stall released", done, 1);
        chk(pre == 1, "R3 one cycle after ack before cut", pre, 1);
        chk(jlast == (NG - 1) * KS, "R7 release one cycle after full", jlast, (NG - 1) * KS);
        chk(rail_sel == tgt, "R6 rail_sel final", rail_sel, tgt);
        cur_rail = tgt;
        repeat (3) begin
            @(negedge clk);
            chk(!busy && !stall, "R8 no follow-on switch", {busy, stall}, 0);
            chk(bank(tgt) == '1 && bank(old) == '0, "R8 target kept",
                {bank(tgt), bank(old)}, {low_ones(NG), {NG{1'b0}}});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_same_rail();
        do_switch(1'b1, 5, 3, 1'b1);
        test_same_rail();
        do_switch(1'b0, 0, 0, 1'b0);
        do_switch(1'b1, 1, 1, 1'b0);
        do_switch(1'b0, 12, 6, 1'b1);
        test_same_rail();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule